// File: doc/BRIEF.md
# Descriptor Ring Index Tracker

This block keeps the four ring indices of an Ethernet DMA engine: a receive producer and consumer and a transmit producer and consumer. Software sets the size of each ring as its last valid slot number (entry count minus one), and writes the index that it owns: the receive consumer, as it releases slots, and the transmit producer, as it queues frames. The block moves the two hardware-owned indices forward when the abstracted datapath signals that a frame is finished.

For every received frame that is accepted, the block builds a 32-bit status word from the frame length, the error inputs and the descriptor control word of the slot. It stores that word in a small status memory indexed by slot. It detects when the receive ring is empty or full, drops frames that arrive into a full ring and records this in a sticky overrun flag, and raises a one-cycle interrupt request when the descriptor asks for one. On the transmit side it decodes the current descriptor control word into a frame length and a last-fragment marker. It reports a two-bit activity status.

Top module: `dma_ring_tracker`

## Requirements
- R1: The ring size inputs hold the last slot number, which is the entry count minus one. Each index steps to 0 after it reaches that last slot.
- R2: While rst_n is low, and while the enable of a direction is low, that direction's indices are 0. Software writes and done events for that direction are ignored. Disabling receive also clears rx_overrun.
- R3: A software write to the receive consumer or to the transmit producer appears on the index output one cycle later.
- R4: rx_empty is 1 exactly when the receive producer equals the receive consumer. rx_full is 1 exactly when the producer's next slot, after wrap, equals the consumer.
- R5: An rx_done pulse that arrives while receive is enabled and the ring is not full stores a status word at the producer's slot and advances the producer one cycle later.
- R6: Layout of the receive status word: bits 10:0 hold the stored length minus one. Error input bit i lands at word bit 23+i, so rx_err[3] (the range error) sits at bit 26. Bit 31 is the OR of the five other error bits (mask 0x1B800000).
- R7: An rx_done pulse that arrives while the ring is full is dropped. The producer and the status memory are left unchanged, and rx_overrun is set and stays set.
- R8: rx_irq is high for one cycle, one cycle after an accepted frame whose descriptor control word has bit 31 set. It stays low otherwise.
- R9: A tx_done pulse advances the transmit consumer when it differs from the transmit producer. It is ignored when the two are equal.
- R10: status_bits[0] is rx_en. status_bits[1] is 1 when tx_en is high and the transmit consumer differs from the transmit producer.
- R11: From tx_desc_ctrl, tx_frame_len is bits 10:0 plus one and tx_frame_last is bit 30. Both follow the input without delay.
- R12: The receive buffer size is rx_desc_ctrl bits 10:0 plus one. A frame longer than the buffer is stored at buffer size, and bit 29 of its status word is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive direction enable |
| tx_en | input | 1 | Transmit direction enable |
| rx_last_idx | input | IDX_W | Receive ring entry count minus one |
| tx_last_idx | input | IDX_W | Transmit ring entry count minus one |
| sw_rx_cons_wr | input | 1 | Write strobe for the receive consumer |
| sw_rx_cons_val | input | IDX_W | New receive consumer value |
| sw_tx_prod_wr | input | 1 | Write strobe for the transmit producer |
| sw_tx_prod_val | input | IDX_W | New transmit producer value |
| rx_done | input | 1 | Receive frame finished event |
| rx_len | input | 12 | Received frame length in bytes (1 to 2048) |
| rx_err | input | 6 | Receive error flags, bit 3 is the range error |
| rx_desc_ctrl | input | 32 | Control word of the receive descriptor at the producer slot |
| tx_done | input | 1 | Transmit frame finished event |
| tx_desc_ctrl | input | 32 | Control word of the transmit descriptor at the consumer slot |
| stat_rd_idx | input | IDX_W | Status memory read slot |
| stat_rd_word | output | 32 | Status word stored at stat_rd_idx |
| rx_prod_idx | output | IDX_W | Receive producer index |
| rx_cons_idx | output | IDX_W | Receive consumer index |
| tx_prod_idx | output | IDX_W | Transmit producer index |
| tx_cons_idx | output | IDX_W | Transmit consumer index |
| rx_empty | output | 1 | Receive ring empty |
| rx_full | output | 1 | Receive ring full |
| rx_overrun | output | 1 | Sticky flag: a frame was dropped |
| rx_irq | output | 1 | One-cycle interrupt request |
| tx_frame_len | output | 12 | Decoded transmit frame length |
| tx_frame_last | output | 1 | Decoded last-fragment marker |
| status_bits | output | 2 | Bit 0 receive active, bit 1 transmit active |

## Verification
The index outputs, rx_overrun, rx_irq and the status memory are registered, so each is due on the first rising edge after the cycle that carried the event or software write. rx_empty, rx_full and status_bits follow those registers and the enables with no further delay. tx_frame_len, tx_frame_last and stat_rd_word are combinational. The bench changes inputs on the falling edge, holds each event for one cycle and samples at the next falling edge, which is exactly one rising edge later. It checks that rx_irq drops again one cycle after that. It compares stored status words against values worked out from the bit layout in R6 and R12.

// File: rtl/ring_pkg.sv
// Shared constants and helper functions for the descriptor ring tracker.
// Assumes 32-bit descriptor and status words and 11-bit length fields.
package ring_pkg;
    localparam int WORD_W      = 32;
    localparam int LEN_W       = 12;
    localparam int ERR_W       = 6;
    localparam int ERR_LSB     = 23;
    localparam int RANGE_ERR   = 3;
    localparam int TRUNC_BIT   = 29;
    localparam int SUMMARY_BIT = 31;
    localparam int IRQ_BIT     = 31;
    localparam int LAST_BIT    = 30;
    localparam int NUM_PTRS    = 4;

    // Slot numbers of the four index registers in the pointer array.
    typedef enum int {
        PTR_RX_PROD = 0,
        PTR_RX_CONS = 1,
        PTR_TX_PROD = 2,
        PTR_TX_CONS = 3
    } ptr_slot_e;

    // Builds a receive status word from the stored length, truncation and errors.
    function automatic logic [WORD_W-1:0] make_rx_status(
        input logic [LEN_W-1:0] stored_len,
        input logic             trunc,
        input logic [ERR_W-1:0] err
    );
        logic [WORD_W-1:0] w;
        logic [ERR_W-1:0]  summary_mask;
        summary_mask                  = '1;
        summary_mask[RANGE_ERR]       = 1'b0;
        w                             = '0;
        w[10:0]                       = 11'(stored_len - LEN_W'(1));
        w[ERR_LSB +: ERR_W]           = err;
        w[TRUNC_BIT]                  = trunc;
        w[SUMMARY_BIT]                = |(err & summary_mask);
        return w;
    endfunction
endpackage

// File: rtl/ring_ptr.sv
// One ring index register. It clears, takes a software load, or steps by
// one and wraps to zero after the programmed last slot.
// Assumes the clear takes priority over the load, and the load over the step.
module ring_ptr #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [IDX_W-1:0] last,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);
    // Holds the index and applies clear, load or a wrapping step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx <= '0;
        end else if (load) begin
            idx <= load_val;
        end else if (step) begin
            idx <= (idx == last) ? '0 : idx + IDX_W'(1);
        end
    end
endmodule

// File: rtl/rx_stat_mem.sv
// Status memory with one word per ring slot: one write port and a
// combinational read port. All words are cleared by reset.
module rx_stat_mem #(
    parameter int IDX_W  = 3,
    parameter int WORD_W = 32,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Clears all words on reset, otherwise writes one slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Returns the word at the requested slot.
    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/dma_ring_tracker.sv
// Top of the descriptor ring tracker. It holds four ring indices, accepts or
// drops finished receive frames, writes receive status words, decodes
// transmit descriptors and reports the activity status.
// Assumes software keeps the values it writes within the programmed ring.
module dma_ring_tracker
    import ring_pkg::*;
#(
    parameter int RING_MAX = 8,
    localparam int IDX_W   = $clog2(RING_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              tx_en,
    input  logic [IDX_W-1:0]  rx_last_idx,
    input  logic [IDX_W-1:0]  tx_last_idx,
    input  logic              sw_rx_cons_wr,
    input  logic [IDX_W-1:0]  sw_rx_cons_val,
    input  logic              sw_tx_prod_wr,
    input  logic [IDX_W-1:0]  sw_tx_prod_val,
    input  logic              rx_done,
    input  logic [11:0]       rx_len,
    input  logic [5:0]        rx_err,
    input  logic [31:0]       rx_desc_ctrl,
    input  logic              tx_done,
    input  logic [31:0]       tx_desc_ctrl,
    input  logic [IDX_W-1:0]  stat_rd_idx,
    output logic [31:0]       stat_rd_word,
    output logic [IDX_W-1:0]  rx_prod_idx,
    output logic [IDX_W-1:0]  rx_cons_idx,
    output logic [IDX_W-1:0]  tx_prod_idx,
    output logic [IDX_W-1:0]  tx_cons_idx,
    output logic              rx_empty,
    output logic              rx_full,
    output logic              rx_overrun,
    output logic              rx_irq,
    output logic [11:0]       tx_frame_len,
    output logic              tx_frame_last,
    output logic [1:0]        status_bits
);
    logic [IDX_W-1:0]  ptr_idx    [NUM_PTRS];
    logic [IDX_W-1:0]  ptr_last   [NUM_PTRS];
    logic [IDX_W-1:0]  ptr_ld_val [NUM_PTRS];
    logic              ptr_clr    [NUM_PTRS];
    logic              ptr_ld     [NUM_PTRS];
    logic              ptr_step   [NUM_PTRS];

    logic [IDX_W-1:0]  rx_next;
    logic              rx_accept;
    logic              rx_drop;
    logic              tx_step;
    logic [LEN_W-1:0]  buf_size;
    logic              trunc;
    logic [LEN_W-1:0]  stored_len;
    logic [WORD_W-1:0] rx_word;
    logic              unused_ctrl_bits;

    // Marks the control bits that this block does not decode.
    assign unused_ctrl_bits = ^{rx_desc_ctrl[30:11], tx_desc_ctrl[31], tx_desc_ctrl[29:11]};

    // Computes ring occupancy and the receive and transmit events that are acted on.
    always_comb begin
        rx_next   = (rx_prod_idx == rx_last_idx) ? '0 : rx_prod_idx + IDX_W'(1);
        rx_empty  = (rx_prod_idx == rx_cons_idx);
        rx_full   = (rx_next == rx_cons_idx);
        rx_accept = rx_en && rx_done && !rx_full;
        rx_drop   = rx_en && rx_done && rx_full;
        tx_step   = tx_en && tx_done && (tx_cons_idx != tx_prod_idx);
    end

    // Decodes the receive buffer size, clips the length and builds the status word.
    always_comb begin
        buf_size   = {1'b0, rx_desc_ctrl[10:0]} + LEN_W'(1);
        trunc      = (rx_len > buf_size);
        stored_len = trunc ? buf_size : rx_len;
        rx_word    = make_rx_status(stored_len, trunc, rx_err);
    end

    // Sets the controls of the four index registers: software loads two, hardware steps two.
    always_comb begin
        ptr_clr[PTR_RX_PROD]    = !rx_en;
        ptr_last[PTR_RX_PROD]   = rx_last_idx;
        ptr_ld[PTR_RX_PROD]     = 1'b0;
        ptr_ld_val[PTR_RX_PROD] = '0;
        ptr_step[PTR_RX_PROD]   = rx_accept;

        ptr_clr[PTR_RX_CONS]    = !rx_en;
        ptr_last[PTR_RX_CONS]   = rx_last_idx;
        ptr_ld[PTR_RX_CONS]     = sw_rx_cons_wr;
        ptr_ld_val[PTR_RX_CONS] = sw_rx_cons_val;
        ptr_step[PTR_RX_CONS]   = 1'b0;

        ptr_clr[PTR_TX_PROD]    = !tx_en;
        ptr_last[PTR_TX_PROD]   = tx_last_idx;
        ptr_ld[PTR_TX_PROD]     = sw_tx_prod_wr;
        ptr_ld_val[PTR_TX_PROD] = sw_tx_prod_val;
        ptr_step[PTR_TX_PROD]   = 1'b0;

        ptr_clr[PTR_TX_CONS]    = !tx_en;
        ptr_last[PTR_TX_CONS]   = tx_last_idx;
        ptr_ld[PTR_TX_CONS]     = 1'b0;
        ptr_ld_val[PTR_TX_CONS] = '0;
        ptr_step[PTR_TX_CONS]   = tx_step;
    end

    for (genvar g = 0; g < NUM_PTRS; g++) begin : g_ptr
        ring_ptr #(.IDX_W(IDX_W)) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (ptr_clr[g]),
            .last     (ptr_last[g]),
            .load     (ptr_ld[g]),
            .load_val (ptr_ld_val[g]),
            .step     (ptr_step[g]),
            .idx      (ptr_idx[g])
        );
    end

    assign rx_prod_idx = ptr_idx[PTR_RX_PROD];
    assign rx_cons_idx = ptr_idx[PTR_RX_CONS];
    assign tx_prod_idx = ptr_idx[PTR_TX_PROD];
    assign tx_cons_idx = ptr_idx[PTR_TX_CONS];

    rx_stat_mem #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rx_accept),
        .wr_idx  (rx_prod_idx),
        .wr_data (rx_word),
        .rd_idx  (stat_rd_idx),
        .rd_data (stat_rd_word)
    );

    // Keeps the sticky overrun flag until receive is disabled or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) rx_overrun <= 1'b0;
        else if (rx_drop)     rx_overrun <= 1'b1;
    end

    // Raises a one-cycle interrupt request for accepted frames that ask for one.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_irq <= 1'b0;
        else        rx_irq <= rx_accept && rx_desc_ctrl[IRQ_BIT];
    end

    // Decodes the transmit descriptor at the consumer slot.
    assign tx_frame_len  = {1'b0, tx_desc_ctrl[10:0]} + LEN_W'(1);
    assign tx_frame_last = tx_desc_ctrl[LAST_BIT];

    // Forms the activity status: receive enabled, transmit with pending work.
    assign status_bits = {tx_en && (tx_cons_idx != tx_prod_idx), rx_en};
endmodule

// File: rtl/ring_chk.sv
// Checker for the ring tracker, attached by bind. It watches ports only.
module ring_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic             tx_en,
    input logic             rx_done,
    input logic             tx_done,
    input logic [IDX_W-1:0] rx_last_idx,
    input logic [IDX_W-1:0] rx_prod_idx,
    input logic [IDX_W-1:0] rx_cons_idx,
    input logic [IDX_W-1:0] tx_prod_idx,
    input logic [IDX_W-1:0] tx_cons_idx,
    input logic             rx_full,
    input logic             rx_empty,
    input logic             rx_overrun,
    input logic             rx_irq,
    input logic [1:0]       status_bits
);
    // R4
    full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && rx_last_idx != '0) |-> !rx_empty);

    // R7
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_done && rx_full) |=> ($stable(rx_prod_idx) && rx_overrun));

    // R9
    tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_done && tx_cons_idx == tx_prod_idx) |=> $stable(tx_cons_idx));

    // R2
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (rx_prod_idx == '0 && rx_cons_idx == '0 && !rx_overrun));

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $past(rx_done && rx_en));

    // R10
    tx_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_bits[1] |-> tx_en);
endmodule

bind dma_ring_tracker ring_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .tx_en       (tx_en),
    .rx_done     (rx_done),
    .tx_done     (tx_done),
    .rx_last_idx (rx_last_idx),
    .rx_prod_idx (rx_prod_idx),
    .rx_cons_idx (rx_cons_idx),
    .tx_prod_idx (tx_prod_idx),
    .tx_cons_idx (tx_cons_idx),
    .rx_full     (rx_full),
    .rx_empty    (rx_empty),
    .rx_overrun  (rx_overrun),
    .rx_irq      (rx_irq),
    .status_bits (status_bits)
);

// File: tb/sim_dma_ring_tracker.sv
module sim_dma_ring_tracker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_en, tx_en;
    logic [2:0]  rx_last_idx, tx_last_idx;
    logic        sw_rx_cons_wr, sw_tx_prod_wr;
    logic [2:0]  sw_rx_cons_val, sw_tx_prod_val;
    logic        rx_done, tx_done;
    logic [11:0] rx_len;
    logic [5:0]  rx_err;
    logic [31:0] rx_desc_ctrl, tx_desc_ctrl;
    logic [2:0]  stat_rd_idx;
    logic [31:0] stat_rd_word;
    logic [2:0]  rx_prod_idx, rx_cons_idx, tx_prod_idx, tx_cons_idx;
    logic        rx_empty, rx_full, rx_overrun, rx_irq, tx_frame_last;
    logic [11:0] tx_frame_len;
    logic [1:0]  status_bits;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    dma_ring_tracker #(.RING_MAX(8)) u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_rx(input logic [11:0] len, input logic [5:0] err, input logic [31:0] ctrl);
        @(negedge clk);
        rx_done = 1'b1; rx_len = len; rx_err = err; rx_desc_ctrl = ctrl;
        @(negedge clk);
        rx_done = 1'b0;
    endtask

    task automatic pulse_tx();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic write_rx_cons(input logic [2:0] v);
        @(negedge clk); sw_rx_cons_wr = 1'b1; sw_rx_cons_val = v;
        @(negedge clk); sw_rx_cons_wr = 1'b0;
    endtask

    task automatic write_tx_prod(input logic [2:0] v);
        @(negedge clk); sw_tx_prod_wr = 1'b1; sw_tx_prod_val = v;
        @(negedge clk); sw_tx_prod_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R2 rx_prod after reset", 32'(rx_prod_idx), 0);
        check("R2 tx_cons after reset", 32'(tx_cons_idx), 0);
        check("R4 empty after reset", 32'(rx_empty), 1);
        check("R4 not full after reset", 32'(rx_full), 0);
        check("R10 status after reset", 32'(status_bits), 0);
        @(negedge clk); rx_en = 1'b1; tx_en = 1'b1;
        @(negedge clk);
        check("R10 status rx on tx idle", 32'(status_bits), 32'h1);
    endtask

    task automatic t_rx_fill();
        pulse_rx(12'd60, 6'b000000, 32'h8000_05FF);
        check("R5 prod after frame", 32'(rx_prod_idx), 1);
        check("R8 irq pulse", 32'(rx_irq), 1);
        check("R4 not empty", 32'(rx_empty), 0);
        stat_rd_idx = 3'd0; #1;
        check("R6 word len only", stat_rd_word, 32'h0000_003B);
        @(negedge clk);
        check("R8 irq drops", 32'(rx_irq), 0);
        pulse_rx(12'd100, 6'b000001, 32'h0000_05FF);
        check("R8 no irq without bit 31", 32'(rx_irq), 0);
        stat_rd_idx = 3'd1; #1;
        check("R6 word crc-type error", stat_rd_word, 32'h8080_0063);
        pulse_rx(12'd64, 6'b001000, 32'h0000_05FF);
        stat_rd_idx = 3'd2; #1;
        check("R6 range error no summary", stat_rd_word, 32'h0400_003F);
        check("R4 full at last slot", 32'(rx_full), 1);
    endtask

    task automatic t_rx_overrun();
        pulse_rx(12'd80, 6'b000000, 32'h8000_05FF);
        check("R7 prod held", 32'(rx_prod_idx), 3);
        check("R7 overrun set", 32'(rx_overrun), 1);
        check("R7 no irq on drop", 32'(rx_irq), 0);
        stat_rd_idx = 3'd3; #1;
        check("R7 memory untouched", stat_rd_word, 0);
        write_rx_cons(3'd2);
        check("R3 rx cons written", 32'(rx_cons_idx), 2);
        check("R4 not full after release", 32'(rx_full), 0);
        check("R7 overrun sticky", 32'(rx_overrun), 1);
        pulse_rx(12'd200, 6'b000000, 32'h0000_003F);
        check("R1 rx prod wraps", 32'(rx_prod_idx), 0);
        stat_rd_idx = 3'd3; #1;
        check("R12 truncated word", stat_rd_word, 32'h2000_003F);
        write_rx_cons(3'd0);
        check("R4 empty again", 32'(rx_empty), 1);
    endtask

    task automatic t_tx();
        tx_desc_ctrl = 32'h4000_05E9; #1;
        check("R11 tx len", 32'(tx_frame_len), 1514);
        check("R11 tx last", 32'(tx_frame_last), 1);
        tx_desc_ctrl = 32'h0000_003B; #1;
        check("R11 tx len short", 32'(tx_frame_len), 60);
        check("R11 tx not last", 32'(tx_frame_last), 0);
        write_tx_prod(3'd2);
        check("R3 tx prod written", 32'(tx_prod_idx), 2);
        check("R10 tx active", 32'(status_bits), 32'h3);
        pulse_tx();
        check("R9 tx cons 1", 32'(tx_cons_idx), 1);
        pulse_tx();
        check("R9 tx cons 2", 32'(tx_cons_idx), 2);
        check("R10 tx idle", 32'(status_bits), 32'h1);
        pulse_tx();
        check("R9 done ignored when idle", 32'(tx_cons_idx), 2);
        write_tx_prod(3'd1);
        pulse_tx(); pulse_tx();
        check("R1 tx cons wraps", 32'(tx_cons_idx), 0);
        pulse_tx();
        check("R9 tx cons reaches prod", 32'(tx_cons_idx), 1);
    endtask

    task automatic t_disable_and_small();
        @(negedge clk); rx_en = 1'b0;
        @(negedge clk);
        check("R2 rx prod cleared", 32'(rx_prod_idx), 0);
        check("R2 overrun cleared", 32'(rx_overrun), 0);
        check("R10 rx inactive", 32'(status_bits[0]), 0);
        pulse_rx(12'd60, 6'b000000, 32'h0000_05FF);
        check("R2 done ignored while off", 32'(rx_prod_idx), 0);
        write_rx_cons(3'd2);
        check("R2 sw write ignored while off", 32'(rx_cons_idx), 0);
        @(negedge clk); rx_last_idx = 3'd1; rx_en = 1'b1;
        pulse_rx(12'd60, 6'b000000, 32'h0000_05FF);
        check("R1 two-entry ring full", 32'(rx_full), 1);
        write_rx_cons(3'd1);
        pulse_rx(12'd60, 6'b000000, 32'h0000_05FF);
        check("R1 two-entry wrap", 32'(rx_prod_idx), 0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R2 reset clears tx cons", 32'(tx_cons_idx), 0);
        check("R2 reset clears tx prod", 32'(tx_prod_idx), 0);
    endtask

    initial begin
        rst_n = 1'b0; rx_en = 1'b0; tx_en = 1'b0;
        rx_last_idx = 3'd3; tx_last_idx = 3'd3;
        sw_rx_cons_wr = 1'b0; sw_tx_prod_wr = 1'b0;
        sw_rx_cons_val = '0; sw_tx_prod_val = '0;
        rx_done = 1'b0; tx_done = 1'b0; rx_len = 12'd1; rx_err = '0;
        rx_desc_ctrl = '0; tx_desc_ctrl = '0; stat_rd_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_fill();
        t_rx_overrun();
        t_tx();
        t_disable_and_small();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule